// File: doc/BRIEF.md
# Descriptor List Sequencer

This block is the control engine of one DMA channel running from a list of buffer descriptors held in memory. Software hands it the address of the list, the number of valid descriptors and a flag that asks for the list to repeat forever. On start it fetches each descriptor over a simple single-word read port, one word at a time. It decodes the source and destination addresses, the per-side burst settings, the byte count and the completion-event request. It then presents one transfer command to an external data mover and holds it until the mover reports completion.

Each descriptor occupies 32 bytes, so descriptor i begins at base + 32·i. After every entry the block raises a per-entry event if that entry asked for one. After the last entry it either raises an end-of-list event and goes idle, or, in repeat mode, wraps to the first descriptor. A descriptor that names an address not aligned to 16 bytes or an unsupported beat size parks the block in an error state, and so does an empty list. A stop request ends the walk once the current entry has finished.

Top module: `desc_list_seq`

## Requirements
- R1: Out of reset the block is idle. `mem_req`, `cmd_valid`, `busy`, `err` and all three event outputs are low.
- R2: A start with a non-zero count, while not busy, reads the eight words of descriptor i at byte addresses base+32·i+4·k for k = 0..7, in ascending k. Each read is a one-cycle `mem_req` pulse. The next request is not raised until `mem_rvalid` has returned the previous word.
- R3: The command carries the following fields. The source address is {word1, word0} and the destination address is {word3, word2}. The byte count is word6. Word4 gives the source side and word5 the destination side: burst type from bits [1:0], size code from bits [6:4] and beat count from bits [15:8]. `cmd_valid` stays high with all fields stable until the cycle in which `mover_done` is sampled.
- R4: `evt_entry_done` pulses for one cycle, in the cycle after `mover_done`, exactly when bit 0 of word7 of that entry is 1. Other bits of word7 have no effect.
- R5: Without repeat mode, when the entry with index count−1 completes, `evt_list_end` pulses in the same cycle as the per-entry event slot and the block returns to idle (`busy` low).
- R6: In repeat mode, the entry after index count−1 is index 0, and `evt_list_end` never pulses.
- R7: If the source or destination address of a fetched descriptor has any of bits [3:0] set, the block enters the error state (`err` high, `busy` low). No command is raised for that descriptor.
- R8: If either size code of a fetched descriptor is greater than 4, the block enters the error state without raising a command.
- R9: A start with a count of zero enters the error state at once and issues no memory read.
- R10: A start while busy produces a one-cycle `evt_busy` pulse in the next cycle. It has no effect on the running list.
- R11: A `stop` pulse while busy lets the current entry finish, then returns the block to idle. No further reads or commands are issued.
- R12: The error state is left only by a start. A start with a valid list clears `err` in the next cycle and begins a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking the list |
| stop | input | 1 | End the walk after the current entry |
| rollback | input | 1 | Repeat the list endlessly |
| list_base | input | AW | Byte address of descriptor 0 |
| list_count | input | CNT_W | Number of valid descriptors |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| cmd_valid | output | 1 | Transfer command present |
| cmd_src | output | 64 | Source address |
| cmd_dst | output | 64 | Destination address |
| cmd_bytes | output | 32 | Total bytes of the entry |
| cmd_src_burst | output | 2 | Source burst type |
| cmd_src_size | output | 3 | Source size code (2^n bytes per beat) |
| cmd_src_beats | output | 8 | Source burst length |
| cmd_dst_burst | output | 2 | Destination burst type |
| cmd_dst_size | output | 3 | Destination size code |
| cmd_dst_beats | output | 8 | Destination burst length |
| mover_done | input | 1 | Data mover finished the current command |
| evt_entry_done | output | 1 | Per-entry completion event |
| evt_list_end | output | 1 | Whole list completed |
| evt_busy | output | 1 | Start refused because a walk is running |
| err | output | 1 | Error state |
| busy | output | 1 | Fetching or transferring |

## Verification
The bench builds the block with a 16-bit read address and a 3-bit descriptor count. This keeps every descriptor address small while letting a two-entry list wrap several times in repeat mode. The count is narrow enough that the last-index compare (count−1) is exercised with counts of 0, 1, 2 and 3. The extra control bits in the descriptor words are filled with noise, so any slip in the field positions shows up in the command.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int DESC_WORDS    = 8;
  localparam int WSEL_W        = $clog2(DESC_WORDS);
  localparam int DESC_SHIFT    = 5;   // 32-byte descriptors
  localparam int ALIGN_BITS    = 4;   // 16-byte address alignment
  localparam int MAX_SIZE_CODE = 4;   // 16 bytes per beat

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_ERR   = 2'd3
  } dsq_state_e;

  typedef struct packed {
    logic [1:0] burst;
    logic [2:0] size;
    logic [7:0] beats;
  } dsq_side_t;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] dst;
    logic [31:0] bytes;
    dsq_side_t   s;
    dsq_side_t   d;
    logic        ioc;
  } dsq_cmd_t;
endpackage

// File: rtl/dsq_fetch.sv
module dsq_fetch
  import dsq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [AW-1:0]            go_addr,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_rvalid,
  input  logic [31:0]              mem_rdata,
  output logic [DESC_WORDS*32-1:0] words,
  output logic                     fetch_done
);

  logic              act_q, act_d;
  logic              pend_q, pend_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              done_q, done_d;
  logic              cap;

  assign cap        = act_q & pend_q & mem_rvalid;
  assign mem_req    = act_q & ~pend_q;
  assign mem_addr   = addr_q + AW'({wsel_q, 2'b00});
  assign fetch_done = done_q;

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    wsel_d = wsel_q;
    addr_d = addr_q;
    done_d = 1'b0;
    if (go) begin
      act_d  = 1'b1;
      pend_d = 1'b0;
      wsel_d = '0;
      addr_d = go_addr;
    end else if (act_q) begin
      if (!pend_q) begin
        pend_d = 1'b1;
      end else if (mem_rvalid) begin
        pend_d = 1'b0;
        if (wsel_q == WSEL_W'(DESC_WORDS - 1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          wsel_d = wsel_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      wsel_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      wsel_q <= wsel_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_word
    logic        en;
    logic [31:0] w_q;
    assign en = cap & (wsel_q == WSEL_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  w_q <= '0;
      else if (en) w_q <= mem_rdata;
    end
    assign words[32*k +: 32] = w_q;
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R2

  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> $past(mem_rvalid)); // R2

endmodule

// File: rtl/dsq_decode.sv
module dsq_decode
  import dsq_pkg::*;
(
  input  logic [DESC_WORDS*32-1:0] words,
  output dsq_cmd_t                 cmd,
  output logic                     misalign,
  output logic                     badsize
);

  logic [31:0] w [DESC_WORDS];

  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_split
    assign w[k] = words[32*k +: 32];
  end

  always_comb begin
    cmd.src     = {w[1], w[0]};
    cmd.dst     = {w[3], w[2]};
    cmd.s.burst = w[4][1:0];
    cmd.s.size  = w[4][6:4];
    cmd.s.beats = w[4][15:8];
    cmd.d.burst = w[5][1:0];
    cmd.d.size  = w[5][6:4];
    cmd.d.beats = w[5][15:8];
    cmd.bytes   = w[6];
    cmd.ioc     = w[7][0];
  end

  assign misalign = (|cmd.src[ALIGN_BITS-1:0]) | (|cmd.dst[ALIGN_BITS-1:0]);
  assign badsize  = (cmd.s.size > 3'(MAX_SIZE_CODE)) |
                    (cmd.d.size > 3'(MAX_SIZE_CODE));

  // reserved descriptor bits carry no function
  logic unused_bits;
  assign unused_bits = ^{w[4][31:16], w[4][7], w[4][3:2],
                         w[5][31:16], w[5][7], w[5][3:2], w[7][31:1]};

endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             rollback,
  input  logic [AW-1:0]    list_base,
  input  logic [CNT_W-1:0] list_count,
  input  logic             fetch_done,
  input  logic             misalign,
  input  logic             badsize,
  input  logic             ioc,
  input  logic             mover_done,
  output logic             fetch_go,
  output logic [AW-1:0]    fetch_addr,
  output logic             cmd_valid,
  output logic             evt_entry_done,
  output logic             evt_list_end,
  output logic             evt_busy,
  output logic             err,
  output logic             busy
);

  dsq_state_e       st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    base_q, base_d;
  logic             roll_q, roll_d;
  logic             stop_q, stop_d;
  logic             go_q, go_d;
  logic             ent_q, ent_d;
  logic             end_q, end_d;
  logic             bsy_q, bsy_d;
  logic             last;

  assign busy           = (st_q == ST_FETCH) | (st_q == ST_XFER);
  assign err            = (st_q == ST_ERR);
  assign cmd_valid      = (st_q == ST_XFER);
  assign fetch_go       = go_q;
  assign fetch_addr     = base_q + (AW'(idx_q) << DESC_SHIFT);
  assign evt_entry_done = ent_q;
  assign evt_list_end   = end_q;
  assign evt_busy       = bsy_q;
  assign last           = (idx_q == cnt_q - CNT_W'(1));

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    roll_d = roll_q;
    stop_d = stop_q | (stop & busy);
    go_d   = 1'b0;
    ent_d  = 1'b0;
    end_d  = 1'b0;
    bsy_d  = start & busy;
    case (st_q)
      ST_IDLE, ST_ERR: begin
        if (start) begin
          stop_d = 1'b0;
          if (list_count == '0) begin
            st_d = ST_ERR;
          end else begin
            st_d   = ST_FETCH;
            idx_d  = '0;
            cnt_d  = list_count;
            base_d = list_base;
            roll_d = rollback;
            go_d   = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (fetch_done) begin
          if (misalign | badsize) begin
            st_d   = ST_ERR;
            stop_d = 1'b0;
          end else begin
            st_d = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (mover_done) begin
          ent_d = ioc;
          if (last && !roll_q) begin
            end_d  = 1'b1;
            st_d   = ST_IDLE;
            stop_d = 1'b0;
          end else if (stop_q | stop) begin
            st_d   = ST_IDLE;
            stop_d = 1'b0;
          end else begin
            idx_d = last ? '0 : idx_q + CNT_W'(1);
            go_d  = 1'b1;
            st_d  = ST_FETCH;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      roll_q <= 1'b0;
      stop_q <= 1'b0;
      go_q   <= 1'b0;
      ent_q  <= 1'b0;
      end_q  <= 1'b0;
      bsy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
      roll_q <= roll_d;
      stop_q <= stop_d;
      go_q   <= go_d;
      ent_q  <= ent_d;
      end_q  <= end_d;
      bsy_q  <= bsy_d;
    end
  end

  AST_ENTRY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_entry_done |-> $past(mover_done)); // R4

  AST_END_NOT_ROLLING: assert property (@(posedge clk) disable iff (!rst_n)
    evt_list_end |-> !roll_q); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(fetch_done) || $past(start))); // R7

  AST_BUSY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_busy |-> ($past(start) && $past(busy))); // R10

endmodule

// File: rtl/desc_list_seq.sv
module desc_list_seq
  import dsq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             rollback,
  input  logic [AW-1:0]    list_base,
  input  logic [CNT_W-1:0] list_count,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             cmd_valid,
  output logic [63:0]      cmd_src,
  output logic [63:0]      cmd_dst,
  output logic [31:0]      cmd_bytes,
  output logic [1:0]       cmd_src_burst,
  output logic [2:0]       cmd_src_size,
  output logic [7:0]       cmd_src_beats,
  output logic [1:0]       cmd_dst_burst,
  output logic [2:0]       cmd_dst_size,
  output logic [7:0]       cmd_dst_beats,
  input  logic             mover_done,
  output logic             evt_entry_done,
  output logic             evt_list_end,
  output logic             evt_busy,
  output logic             err,
  output logic             busy
);

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [DESC_WORDS*32-1:0] words;
  logic                     fetch_go, fetch_done;
  logic [AW-1:0]            fetch_addr;
  dsq_cmd_t                 cmd;
  logic                     misalign, badsize;

  dsq_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_sn),
    .go         (fetch_go),
    .go_addr    (fetch_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .words      (words),
    .fetch_done (fetch_done)
  );

  dsq_decode u_decode (
    .words    (words),
    .cmd      (cmd),
    .misalign (misalign),
    .badsize  (badsize)
  );

  dsq_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sn),
    .start          (start),
    .stop           (stop),
    .rollback       (rollback),
    .list_base      (list_base),
    .list_count     (list_count),
    .fetch_done     (fetch_done),
    .misalign       (misalign),
    .badsize        (badsize),
    .ioc            (cmd.ioc),
    .mover_done     (mover_done),
    .fetch_go       (fetch_go),
    .fetch_addr     (fetch_addr),
    .cmd_valid      (cmd_valid),
    .evt_entry_done (evt_entry_done),
    .evt_list_end   (evt_list_end),
    .evt_busy       (evt_busy),
    .err            (err),
    .busy           (busy)
  );

  assign cmd_src       = cmd.src;
  assign cmd_dst       = cmd.dst;
  assign cmd_bytes     = cmd.bytes;
  assign cmd_src_burst = cmd.s.burst;
  assign cmd_src_size  = cmd.s.size;
  assign cmd_src_beats = cmd.s.beats;
  assign cmd_dst_burst = cmd.d.burst;
  assign cmd_dst_size  = cmd.d.size;
  assign cmd_dst_beats = cmd.d.beats;

  AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |-> (cmd_src[3:0] == 4'h0 && cmd_dst[3:0] == 4'h0)); // R7

  AST_CMD_SIZE_OK: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |-> (cmd_src_size <= 3'd4 && cmd_dst_size <= 3'd4)); // R8

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_valid && $past(cmd_valid)) |->
      ($stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_bytes))); // R3

  AST_NO_READ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |-> !mem_req); // R2

endmodule

// File: tb/desc_list_seq_bench.sv
module desc_list_seq_bench;
  localparam int AW    = 16;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start, stop, rollback;
  logic [AW-1:0]    list_base;
  logic [CNT_W-1:0] list_count;
  logic             mem_req;
  logic [AW-1:0]    mem_addr;
  logic             mem_rvalid;
  logic [31:0]      mem_rdata;
  logic             cmd_valid;
  logic [63:0]      cmd_src, cmd_dst;
  logic [31:0]      cmd_bytes;
  logic [1:0]       cmd_src_burst, cmd_dst_burst;
  logic [2:0]       cmd_src_size, cmd_dst_size;
  logic [7:0]       cmd_src_beats, cmd_dst_beats;
  logic             mover_done;
  logic             evt_entry_done, evt_list_end, evt_busy, err, busy;

  always #2 clk = ~clk;

  desc_list_seq #(.AW(AW), .CNT_W(CNT_W)) u_desc_list_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .rollback(rollback),
    .list_base(list_base), .list_count(list_count),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
    .cmd_dst(cmd_dst), .cmd_bytes(cmd_bytes),
    .cmd_src_burst(cmd_src_burst), .cmd_src_size(cmd_src_size),
    .cmd_src_beats(cmd_src_beats), .cmd_dst_burst(cmd_dst_burst),
    .cmd_dst_size(cmd_dst_size), .cmd_dst_beats(cmd_dst_beats),
    .mover_done(mover_done), .evt_entry_done(evt_entry_done),
    .evt_list_end(evt_list_end), .evt_busy(evt_busy), .err(err), .busy(busy)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int nreads = 0;
  int n_cmd  = 0;
  int n_end  = 0;
  logic prev_cmd = 1'b0;
  logic [31:0] mem [int];
  int addr_q [$];
  logic resp_pend = 1'b0;
  logic [AW-1:0] resp_addr = '0;

  function automatic logic [31:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory responder and event monitor, observed away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      resp_pend  = 1'b0;
      prev_cmd   = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
      if (resp_pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd(int'(resp_addr));
      end
      resp_pend = mem_req;
      resp_addr = mem_addr;
      if (mem_req) begin
        addr_q.push_back(int'(mem_addr));
        nreads++;
      end
      if (cmd_valid && !prev_cmd) n_cmd++;
      if (evt_list_end) n_end++;
      prev_cmd = cmd_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put_desc(input int a, input logic [63:0] src, input logic [63:0] dst,
                          input logic [31:0] stc, input logic [31:0] dtc,
                          input logic [31:0] nbytes, input logic [31:0] ioc);
    mem[a]      = src[31:0];
    mem[a + 4]  = src[63:32];
    mem[a + 8]  = dst[31:0];
    mem[a + 12] = dst[63:32];
    mem[a + 16] = stc;
    mem[a + 20] = dtc;
    mem[a + 24] = nbytes;
    mem[a + 28] = ioc;
  endtask

  task automatic go(input int base, input int cnt, input bit roll);
    start = 1'b1; list_base = AW'(base); list_count = CNT_W'(cnt); rollback = roll;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_cmd();
    for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
    chk(cmd_valid, "R2 command timeout", 64'(cmd_valid), 64'h1);
  endtask

  task automatic do_entry(input int base, input int idx, input bit exp_end,
                          input bit do_stop);
    int a;
    bit ok;
    logic [31:0] stc, dtc, iw;
    logic [63:0] s0;
    wait_cmd();
    a = base + 32 * idx;
    ok = 1;
    for (int k = 0; k < 8; k++) begin
      if (addr_q.size() == 0) ok = 0;
      else if (addr_q.pop_front() != a + 4 * k) ok = 0;
    end
    chk(ok && addr_q.size() == 0, "R2 read addresses", 64'(a), 64'(a));
    stc = rd(a + 16); dtc = rd(a + 20); iw = rd(a + 28);
    chk(cmd_src == {rd(a + 4), rd(a)}, "R3 src", cmd_src, {rd(a + 4), rd(a)});
    chk(cmd_dst == {rd(a + 12), rd(a + 8)}, "R3 dst", cmd_dst, {rd(a + 12), rd(a + 8)});
    chk(cmd_bytes == rd(a + 24), "R3 bytes", 64'(cmd_bytes), 64'(rd(a + 24)));
    chk({cmd_src_burst, cmd_src_size, cmd_src_beats} == {stc[1:0], stc[6:4], stc[15:8]},
        "R3 src side", 64'({cmd_src_burst, cmd_src_size, cmd_src_beats}),
        64'({stc[1:0], stc[6:4], stc[15:8]}));
    chk({cmd_dst_burst, cmd_dst_size, cmd_dst_beats} == {dtc[1:0], dtc[6:4], dtc[15:8]},
        "R3 dst side", 64'({cmd_dst_burst, cmd_dst_size, cmd_dst_beats}),
        64'({dtc[1:0], dtc[6:4], dtc[15:8]}));
    s0 = cmd_src;
    if (do_stop) begin
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(cmd_valid && cmd_src == s0, "R3 held", cmd_src, s0);
    mover_done = 1'b1;
    @(negedge clk);
    mover_done = 1'b0;
    chk(evt_entry_done == iw[0], "R4 entry event", 64'(evt_entry_done), 64'(iw[0]));
    chk(evt_list_end == exp_end, "R5 list end", 64'(evt_list_end), 64'(exp_end));
    chk(!cmd_valid, "R3 cmd drop", 64'(cmd_valid), 64'h0);
  endtask

  initial begin
    int r0, c0, e0;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; rollback = 1'b0;
    list_base = '0; list_count = '0; mover_done = 1'b0;
    mem_rvalid = 1'b0; mem_rdata = '0;

    // descriptors with noise in reserved control bits
    put_desc(32'h1000, 64'h0000_00A0_2000_0000, 64'h0000_00B0_3000_0010,
             32'hABCD_0419, 32'h5A5A_0F3E, 32'd256, 32'h1);
    put_desc(32'h1020, 64'h0000_00A1_2000_0100, 64'h0000_00B1_3000_0200,
             32'h0000_1002, 32'h0000_8043, 32'd64, 32'h2);     // bit0 clear: no event
    put_desc(32'h1040, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4320,
             32'h0000_FF0C, 32'h0000_0148, 32'd4096, 32'hFFFF_FFFF);
    put_desc(32'h2000, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_5000,
             32'h0000_0221, 32'h0000_0221, 32'd32, 32'h1);
    put_desc(32'h2020, 64'h0000_0000_0000_4100, 64'h0000_0000_0000_5100,
             32'h0000_0331, 32'h0000_0331, 32'd48, 32'h1);
    put_desc(32'h4000, 64'h0000_0000_0000_6000, 64'h0000_0000_0000_7008,
             32'h0000_0120, 32'h0000_0120, 32'd16, 32'h1);     // misaligned dst
    put_desc(32'h5000, 64'h0000_0000_0000_6000, 64'h0000_0000_0000_7000,
             32'h0000_0150, 32'h0000_0120, 32'd16, 32'h1);     // size code 5

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(!mem_req && !cmd_valid && !busy && !err, "R1 idle outputs",
        64'({mem_req, cmd_valid, busy, err}), 64'h0);
    chk(!evt_entry_done && !evt_list_end && !evt_busy, "R1 events",
        64'({evt_entry_done, evt_list_end, evt_busy}), 64'h0);

    // R2..R5 three-entry list
    addr_q.delete();
    go(32'h1000, 3, 1'b0);
    do_entry(32'h1000, 0, 1'b0, 1'b0);
    do_entry(32'h1000, 1, 1'b0, 1'b0);
    do_entry(32'h1000, 2, 1'b1, 1'b0);
    chk(!busy, "R5 idle after end", 64'(busy), 64'h0);

    // R10 start while busy
    addr_q.delete();
    go(32'h1000, 2, 1'b0);
    @(negedge clk);
    start = 1'b1; list_base = 16'h3000; list_count = 3'd1;
    @(negedge clk);
    start = 1'b0;
    chk(evt_busy, "R10 busy event", 64'(evt_busy), 64'h1);
    @(negedge clk);
    chk(!evt_busy, "R10 single pulse", 64'(evt_busy), 64'h0);
    do_entry(32'h1000, 0, 1'b0, 1'b0);
    do_entry(32'h1000, 1, 1'b1, 1'b0);

    // R9 zero count
    addr_q.delete();
    r0 = nreads;
    go(32'h1000, 0, 1'b0);
    chk(err && !busy, "R9 error on empty list", 64'({err, busy}), 64'h2);
    repeat (20) @(negedge clk);
    chk(nreads == r0, "R9 no reads", 64'(nreads), 64'(r0));

    // R6 rollback wrap, R11 stop, R12 leave error via start
    e0 = n_end;
    go(32'h2000, 2, 1'b1);
    chk(!err, "R12 error cleared", 64'(err), 64'h0);
    do_entry(32'h2000, 0, 1'b0, 1'b0);
    do_entry(32'h2000, 1, 1'b0, 1'b0);
    do_entry(32'h2000, 0, 1'b0, 1'b0);
    do_entry(32'h2000, 1, 1'b0, 1'b0);
    do_entry(32'h2000, 0, 1'b0, 1'b1);
    chk(!busy, "R11 idle after stop", 64'(busy), 64'h0);
    r0 = nreads; c0 = n_cmd;
    repeat (30) @(negedge clk);
    chk(nreads == r0 && n_cmd == c0, "R11 no further activity",
        64'(nreads - r0), 64'h0);
    chk(n_end == e0, "R6 no list end while rolling", 64'(n_end - e0), 64'h0);

    // R7 misaligned address
    addr_q.delete();
    c0 = n_cmd;
    go(32'h4000, 1, 1'b0);
    for (int i = 0; i < 100 && !err; i++) @(negedge clk);
    chk(err && !busy, "R7 error state", 64'({err, busy}), 64'h2);
    chk(n_cmd == c0, "R7 no command", 64'(n_cmd - c0), 64'h0);
    repeat (10) @(negedge clk);
    chk(err, "R12 error held", 64'(err), 64'h1);

    // R12 restart from error with a good list
    addr_q.delete();
    go(32'h1040, 1, 1'b0);
    chk(!err && busy, "R12 restart", 64'({err, busy}), 64'h1);
    do_entry(32'h1040, 0, 1'b1, 1'b0);

    // R8 bad size code
    addr_q.delete();
    c0 = n_cmd;
    go(32'h5000, 1, 1'b0);
    for (int i = 0; i < 100 && !err; i++) @(negedge clk);
    chk(err && n_cmd == c0, "R8 size error", 64'({err, 8'(n_cmd - c0)}), 64'h100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule